// File: doc/BRIEF.md
# Gain-Error Integrator with Framed Serial Readout

This block measures how strong the incoming baseband signal is and keeps a running count of how much gain is still missing. On every symbol strobe it takes the signed I and Q samples and forms the magnitude estimate |I|+|Q|. Over a window of 2^WIN_LOG2 strobed samples it averages these magnitudes by a right shift. It subtracts the average from a target level and adds the signed difference into a 12-bit accumulator that saturates. A weak signal therefore drives the value upward, and a strong signal drives it down. The default window of 2048 symbols gives about one update per two thousand symbols.

After each window the accumulator value is queued for a serial shifter. A frame holds sixteen bit periods: four zero pad bits come first, then the 12-bit value with the most significant bit first. An active-low frame strobe stays low across the whole frame. Data changes only when the serial clock rises, so a receiver can take each bit on the falling edge. Each clock phase lasts HALF_DIV core cycles, which gives a 200 ns period at a 200 MHz core clock. A value is only taken into the shifter when no frame is in flight.

The block leaves reset in open-loop mode and reports a fixed gain. The first configuration write selects between open and closed loop and loads the target. In closed loop the reported gain is the accumulator.

Top module: `agc_accum_serial`

## Requirements
- R1: The average magnitude is floor(sum over the window of (|I|+|Q|) / 2^WIN_LOG2), with I and Q as two's-complement values. The most negative input counts as 2^(SAMPLE_W-1).
- R2: At the end of each window with loop_en high, the accumulator becomes its old value plus (target minus average).
- R3: The accumulator clamps at 0 and at 4095 and never wraps.
- R4: A window that completes while loop_en is low leaves the accumulator unchanged. That window still produces a frame.
- R5: Samples presented while sym_stb is low have no effect on the average or on the window count.
- R6: Each completed window starts one frame, on the cycle after the window ends if the shifter is idle. A frame has agc_frame_n low for exactly 16 serial clock rises. Its bits are four 0 pad bits followed by accumulator bits 11 down to 0.
- R7: Within a frame agc_sdata changes only on a cycle where agc_sclk rises. Each high phase and each low phase of agc_sclk lasts HALF_DIV cycles. Outside a frame agc_sclk is low and agc_frame_n is high.
- R8: A frame carries the value the accumulator held when the frame started. A window ending during a frame goes into the next frame only.
- R9: From reset until the first cfg_wr, gain_out equals OPEN_GAIN. After a write, gain_out equals the accumulator if cfg_closed was 1 in the last write, and OPEN_GAIN if it was 0.
- R10: The target equals TGT_INIT until the first cfg_wr. Each cfg_wr loads cfg_target for all windows that end afterwards.
- R11: With a fixed target, a window of lower amplitude than the target raises the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_stb | input | 1 | Marks a valid symbol sample |
| i_samp | input | SAMPLE_W | Signed in-phase sample |
| q_samp | input | SAMPLE_W | Signed quadrature sample |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_target | input | SAMPLE_W+1 | Target magnitude, loaded on cfg_wr |
| cfg_closed | input | 1 | 1 = closed loop, loaded on cfg_wr |
| loop_en | input | 1 | Allows accumulator updates |
| gain_out | output | 12 | Gain word in use |
| agc_sclk | output | 1 | Serial clock |
| agc_frame_n | output | 1 | Frame strobe, active low |
| agc_sdata | output | 1 | Serial data, MSB first after pads |

## Verification
The bench builds the block with 4-bit samples, a 4-symbol window, a 2-cycle clock phase and an accumulator that starts at 100. With these values it can sweep every sample value, including -8, through the windows. It also drives both clamps in a few hundred windows. An update is placed on purpose during a frame that is already in flight, to show that values queue behind a running frame. Junk data on non-strobe cycles, an update with loop_en low, and all three loop-mode states are also checked.

// File: rtl/agc_pkg.sv
// Shared constants for the gain-error integrator: frame layout and gain width.
package agc_pkg;
    localparam int FRAME_LEN = 16;                  // serial clock periods per frame
    localparam int PAD_LEN   = 4;                   // leading zero bits
    localparam int GAIN_W    = FRAME_LEN - PAD_LEN; // accumulator width
    typedef logic [GAIN_W-1:0] gain_t;
endpackage

// File: rtl/agc_win_avg.sv
// Window averager: sums |I|+|Q| over 2^WIN_LOG2 strobed samples and emits the
// floor average together with a one-cycle window-end flag.
// Assumes WIN_LOG2 >= 1; the flag and average are valid in the last strobe cycle.
module agc_win_avg #(
    parameter int SAMPLE_W = 8,
    parameter int WIN_LOG2 = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sym_stb,
    input  logic signed [SAMPLE_W-1:0] i_s,
    input  logic signed [SAMPLE_W-1:0] q_s,
    output logic                       win_end,
    output logic [SAMPLE_W:0]          avg_mag
);
    localparam int MAG_W = SAMPLE_W + 1;
    localparam int SUM_W = MAG_W + WIN_LOG2;

    logic [WIN_LOG2-1:0] cnt;
    logic [SUM_W-1:0]    sum;
    logic [SAMPLE_W-1:0] abs_i, abs_q;
    logic [MAG_W-1:0]    mag;
    logic [SUM_W-1:0]    total;

    // Magnitude estimate and running total including the current sample.
    always_comb begin
        abs_i   = i_s[SAMPLE_W-1] ? $unsigned(-i_s) : $unsigned(i_s);
        abs_q   = q_s[SAMPLE_W-1] ? $unsigned(-q_s) : $unsigned(q_s);
        mag     = MAG_W'(abs_i) + MAG_W'(abs_q);
        total   = sum + SUM_W'(mag);
        win_end = sym_stb && (cnt == '1);
        avg_mag = total[SUM_W-1:WIN_LOG2];
    end

    // Count strobes and accumulate; restart at every window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sum <= '0;
        end else if (sym_stb) begin
            cnt <= cnt + 1'b1;
            sum <= win_end ? '0 : total;
        end
    end
endmodule

// File: rtl/agc_gain_acc.sv
// Gain accumulator: adds (target - average) at each window end with clamping,
// holds the configuration registers and selects the reported gain by loop mode.
// Assumes cfg_wr and win_end do not need ordering: a write lands after the edge.
module agc_gain_acc #(
    parameter int SAMPLE_W  = 8,
    parameter int TGT_INIT  = 64,
    parameter int ACC_INIT  = 2048,
    parameter int OPEN_GAIN = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_end,
    input  logic [SAMPLE_W:0] avg_mag,
    input  logic              loop_en,
    input  logic              cfg_wr,
    input  logic [SAMPLE_W:0] cfg_target,
    input  logic              cfg_closed,
    output agc_pkg::gain_t    acc,
    output agc_pkg::gain_t    gain_out
);
    import agc_pkg::*;
    localparam int MAG_W = SAMPLE_W + 1;
    localparam int EXT_W = GAIN_W + MAG_W + 2;
    localparam logic signed [EXT_W-1:0] GMAX_S = EXT_W'((2 ** GAIN_W) - 1);

    logic [MAG_W-1:0]        target_q;
    logic                    closed_q, cfg_seen;
    logic signed [MAG_W:0]   diff;
    logic signed [EXT_W-1:0] nxt;
    gain_t                   acc_sat;

    // Configuration registers; any write leaves the reset open-loop state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= MAG_W'(TGT_INIT);
            closed_q <= 1'b0;
            cfg_seen <= 1'b0;
        end else if (cfg_wr) begin
            target_q <= cfg_target;
            closed_q <= cfg_closed;
            cfg_seen <= 1'b1;
        end
    end

    // Signed error, widened sum and clamp to the gain range.
    always_comb begin
        diff = $signed({1'b0, target_q}) - $signed({1'b0, avg_mag});
        nxt  = EXT_W'($signed({1'b0, acc})) + EXT_W'(diff);
        if (nxt < 0)           acc_sat = '0;
        else if (nxt > GMAX_S) acc_sat = '1;
        else                   acc_sat = nxt[GAIN_W-1:0];
    end

    // Accumulator update at window end when the loop is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                 acc <= GAIN_W'(ACC_INIT);
        else if (win_end && loop_en) acc <= acc_sat;
    end

    assign gain_out = (cfg_seen && closed_q) ? acc : GAIN_W'(OPEN_GAIN);
endmodule

// File: rtl/agc_serial_tx.sv
// Framed serial shifter: on request, once idle, sends 4 zero pads then the
// 12-bit word MSB first; data moves on sclk rise, each phase HALF_DIV cycles.
// Assumes a request made while busy is held until the frame ends.
module agc_serial_tx #(
    parameter int HALF_DIV = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_req,
    input  agc_pkg::gain_t word,
    output logic           sclk,
    output logic           frame_n,
    output logic           sdata
);
    import agc_pkg::*;
    localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BC_W = $clog2(FRAME_LEN);

    logic                 pend, busy, start;
    logic [HC_W-1:0]      hcnt;
    logic [BC_W-1:0]      bcnt;
    logic [FRAME_LEN-1:0] shreg;

    assign start = pend && !busy;

    // Hold a pending load until the shifter is free.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend && !start) || load_req;
    end

    // Phase timer, bit counter and shift register of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            sclk  <= 1'b0;
            hcnt  <= '0;
            bcnt  <= '0;
            shreg <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            sclk  <= 1'b1;
            hcnt  <= '0;
            bcnt  <= '0;
            shreg <= {PAD_LEN'(0), word};
        end else if (busy) begin
            if (hcnt == HC_W'(HALF_DIV - 1)) begin
                hcnt <= '0;
                if (sclk) begin
                    sclk <= 1'b0;
                end else if (bcnt == BC_W'(FRAME_LEN - 1)) begin
                    busy <= 1'b0;
                end else begin
                    sclk  <= 1'b1;
                    bcnt  <= bcnt + 1'b1;
                    shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    assign frame_n = !busy;
    assign sdata   = busy && shreg[FRAME_LEN-1];
endmodule

// File: rtl/agc_accum_serial.sv
// Top level: window averager feeding the clamped gain accumulator, whose value
// is framed out serially after every window. Assumes one sample per sym_stb.
module agc_accum_serial #(
    parameter int SAMPLE_W  = 8,
    parameter int WIN_LOG2  = 11,
    parameter int HALF_DIV  = 20,
    parameter int TGT_INIT  = 64,
    parameter int ACC_INIT  = 2048,
    parameter int OPEN_GAIN = 2048
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sym_stb,
    input  logic signed [SAMPLE_W-1:0] i_samp,
    input  logic signed [SAMPLE_W-1:0] q_samp,
    input  logic                       cfg_wr,
    input  logic [SAMPLE_W:0]          cfg_target,
    input  logic                       cfg_closed,
    input  logic                       loop_en,
    output logic [11:0]                gain_out,
    output logic                       agc_sclk,
    output logic                       agc_frame_n,
    output logic                       agc_sdata
);
    logic              win_end;
    logic [SAMPLE_W:0] avg_mag;
    agc_pkg::gain_t    acc, gain_w;

    agc_win_avg #(.SAMPLE_W(SAMPLE_W), .WIN_LOG2(WIN_LOG2)) u_avg (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .i_s(i_samp), .q_s(q_samp),
        .win_end(win_end), .avg_mag(avg_mag)
    );

    agc_gain_acc #(.SAMPLE_W(SAMPLE_W), .TGT_INIT(TGT_INIT), .ACC_INIT(ACC_INIT),
                   .OPEN_GAIN(OPEN_GAIN)) u_acc (
        .clk(clk), .rst_n(rst_n), .win_end(win_end), .avg_mag(avg_mag),
        .loop_en(loop_en), .cfg_wr(cfg_wr), .cfg_target(cfg_target),
        .cfg_closed(cfg_closed), .acc(acc), .gain_out(gain_w)
    );

    agc_serial_tx #(.HALF_DIV(HALF_DIV)) u_tx (
        .clk(clk), .rst_n(rst_n), .load_req(win_end), .word(acc),
        .sclk(agc_sclk), .frame_n(agc_frame_n), .sdata(agc_sdata)
    );

    assign gain_out = gain_w;
endmodule

// File: rtl/agc_accum_serial_chk.sv
// Checker for the serial frame timing and open-loop reporting, bound to the top.
module agc_accum_serial_chk #(
    parameter int HALF_DIV  = 20,
    parameter int OPEN_GAIN = 2048
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [11:0] gain_out,
    input logic        agc_sclk,
    input logic        agc_frame_n,
    input logic        agc_sdata
);
    logic        sclk_d, frame_d, sdata_d, seen, rise;
    logic [15:0] run;
    logic [4:0]  bitn, idx;

    assign rise = agc_sclk && !sclk_d;
    assign idx  = bitn + 5'(rise);

    // Previous-cycle copies, phase run length and rise count inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0; frame_d <= 1'b1; sdata_d <= 1'b0;
            seen <= 1'b0; run <= 16'd1; bitn <= '0;
        end else begin
            sclk_d  <= agc_sclk;
            frame_d <= agc_frame_n;
            sdata_d <= agc_sdata;
            if (cfg_wr) seen <= 1'b1;
            run  <= (agc_sclk != sclk_d) ? 16'd1 : ((run == 16'hFFFF) ? run : run + 16'd1);
            bitn <= agc_frame_n ? 5'd0 : idx;
        end
    end

    p_half_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!agc_frame_n && !frame_d && agc_sclk != sclk_d) |-> run == 16'(HALF_DIV));
    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        agc_frame_n |-> !agc_sclk);
    p_data_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!agc_frame_n && !frame_d && agc_sdata != sdata_d) |-> rise);
    p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!agc_frame_n && idx <= 5'd4) |-> !agc_sdata);
    p_frame_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (agc_frame_n && !frame_d) |-> bitn == 5'd16);
    p_open_gain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> gain_out == 12'(OPEN_GAIN));
endmodule

bind agc_accum_serial agc_accum_serial_chk #(.HALF_DIV(HALF_DIV), .OPEN_GAIN(OPEN_GAIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .gain_out(gain_out),
    .agc_sclk(agc_sclk), .agc_frame_n(agc_frame_n), .agc_sdata(agc_sdata)
);

// File: tb/sim_agc_accum_serial.sv
module sim_agc_accum_serial;
    localparam int SW = 4, WL = 2, HD = 2, TI = 10, AI = 100, OG = 2048;
    localparam int WIN = 1 << WL;

    logic clk = 0, rst_n = 0, sym_stb = 0, cfg_wr = 0, cfg_closed = 0, loop_en = 1;
    logic signed [SW-1:0] i_samp = 0, q_samp = 0;
    logic [SW:0] cfg_target = 0;
    logic [11:0] gain_out;
    logic agc_sclk, agc_frame_n, agc_sdata;

    always #2.5 clk = ~clk;

    agc_accum_serial #(.SAMPLE_W(SW), .WIN_LOG2(WL), .HALF_DIV(HD), .TGT_INIT(TI),
                       .ACC_INIT(AI), .OPEN_GAIN(OG)) u0 (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .i_samp(i_samp), .q_samp(q_samp),
        .cfg_wr(cfg_wr), .cfg_target(cfg_target), .cfg_closed(cfg_closed), .loop_en(loop_en),
        .gain_out(gain_out), .agc_sclk(agc_sclk), .agc_frame_n(agc_frame_n), .agc_sdata(agc_sdata)
    );

    int n_chk = 0, n_bad = 0;
    int acc_m = AI, tgt_m = TI, frames = 0, last_word = 0, cyc = 0;
    bit seen_m = 0, closed_m = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int expect_gain();
        return (seen_m && closed_m) ? acc_m : OG;
    endfunction

    // Frame decoder: bits taken on sclk fall, high phase length measured.
    int nbits = 0, hi_run = 0;
    logic [15:0] bits = 0;
    logic p_sclk = 0, p_frame = 1;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!agc_frame_n && p_frame) begin nbits = 0; bits = 0; end
            if (agc_sclk) hi_run++;
            if (!agc_frame_n && !agc_sclk && p_sclk) begin
                bits = {bits[14:0], agc_sdata};
                nbits++;
                chk("R7 high phase", hi_run, HD);
            end
            if (!agc_sclk) hi_run = 0;
            if (agc_frame_n && !p_frame) begin
                chk("R6 frame length", nbits, 16);
                chk("R6 pad bits", int'(bits[15:12]), 0);
                last_word = int'(bits[11:0]);
                frames++;
            end
        end
        p_sclk  = agc_sclk;
        p_frame = agc_frame_n;
    end

    // Watchdog.
    initial begin
        wait (cyc > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic int absv(input int v);
        return v < 0 ? -v : v;
    endfunction

    // One window; fixed values when use_fix, else pattern from seed; gaps insert junk.
    task automatic run_window(input int seed, input bit gaps, input bit use_fix, input int fi, input int fq);
        int sum = 0;
        for (int k = 0; k < WIN; k++) begin
            int iv = use_fix ? fi : ((seed * 7 + k * 3) % 16) - 8;
            int qv = use_fix ? fq : ((seed * 5 + k * 11 + 3) % 16) - 8;
            if (gaps) begin
                @(negedge clk);
                sym_stb = 0; i_samp = -8; q_samp = -8;  // R5 junk, must be ignored
            end
            @(negedge clk);
            sym_stb = 1; i_samp = SW'(iv); q_samp = SW'(qv);
            sum += absv(iv) + absv(qv);
        end
        @(negedge clk);
        sym_stb = 0; i_samp = 7; q_samp = 7;
        if (loop_en) begin
            acc_m = acc_m + tgt_m - (sum >> WL);
            if (acc_m < 0) acc_m = 0;
            if (acc_m > 4095) acc_m = 4095;
        end
    endtask

    task automatic wait_frames(input int target);
        while (frames < target) @(negedge clk);
    endtask

    task automatic cfg(input int t, input bit c);
        @(negedge clk);
        cfg_wr = 1; cfg_target = (SW+1)'(t); cfg_closed = c;
        @(negedge clk);
        cfg_wr = 0;
        tgt_m = t; closed_m = c; seen_m = 1;
    endtask

    initial begin
        int f0, v1, v2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R7 idle frame_n", agc_frame_n, 1);
        chk("R7 idle sclk", agc_sclk, 0);
        chk("R9 reset gain", gain_out, OG);

        // Open loop with reset target: R1 R2 R10, gain stays fixed (R9).
        for (int s = 0; s < 6; s++) begin
            f0 = frames;
            run_window(s, s[0], 0, 0, 0);
            wait_frames(f0 + 1);
            chk("R1 R2 R10 open-loop word", last_word, acc_m);
            chk("R9 open gain", gain_out, OG);
        end

        // Closed loop, new target, sweep with and without junk gaps (R5).
        cfg(20, 1);
        chk("R9 closed gain", gain_out, acc_m);
        for (int s = 0; s < 16; s++) begin
            f0 = frames;
            run_window(s + 3, s[0], 0, 0, 0);
            wait_frames(f0 + 1);
            chk("R1 R5 R10 closed word", last_word, acc_m);
            chk("R9 gain follows acc", gain_out, acc_m);
        end
        // Most negative sample: magnitude 8 each, avg 16.
        f0 = frames;
        run_window(0, 0, 1, -8, -8);
        wait_frames(f0 + 1);
        chk("R1 most negative", last_word, acc_m);

        // R4: loop disabled keeps the value, frame still sent.
        loop_en = 0;
        v1 = acc_m;
        f0 = frames;
        run_window(0, 0, 1, 7, 7);
        wait_frames(f0 + 1);
        chk("R4 hold word", last_word, v1);
        chk("R4 hold gain", gain_out, v1);
        loop_en = 1;

        // R8 and R11: update during a frame goes to the next one; zero input raises value.
        f0 = frames;
        run_window(0, 0, 1, 0, 0);
        v1 = acc_m;
        while (agc_frame_n) @(negedge clk);
        repeat (6) @(negedge clk);
        run_window(0, 0, 1, 0, 0);
        v2 = acc_m;
        wait_frames(f0 + 1);
        chk("R8 first frame", last_word, v1);
        wait_frames(f0 + 2);
        chk("R8 second frame", last_word, v2);
        chk("R11 rises on weak input", int'(v2 > v1), 1);

        // R3 upper clamp.
        cfg(31, 1);
        while (acc_m < 4095) begin
            f0 = frames;
            run_window(0, 0, 1, 0, 0);
            wait_frames(f0 + 1);
        end
        for (int r = 0; r < 3; r++) begin
            f0 = frames;
            run_window(0, 0, 1, 0, 0);
            wait_frames(f0 + 1);
            chk("R3 upper clamp", last_word, 4095);
        end

        // R3 lower clamp.
        cfg(0, 1);
        while (acc_m > 0) begin
            f0 = frames;
            run_window(0, 0, 1, -8, 7);
            wait_frames(f0 + 1);
        end
        for (int r = 0; r < 3; r++) begin
            f0 = frames;
            run_window(0, 0, 1, -8, -8);
            wait_frames(f0 + 1);
            chk("R3 lower clamp", last_word, 0);
            chk("R9 gain at clamp", gain_out, 0);
        end

        // R9 back to open loop by write.
        cfg(5, 0);
        chk("R9 reopened gain", gain_out, OG);
        chk("R9 model agrees", expect_gain(), OG);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule